// File: doc/BRIEF.md
# PCIe Inbound BAR and Window Decoder

This block takes the address of each request coming in from a PCIe endpoint link and decides where in local memory it lands. Decoding runs in two stages. First the address is compared with two programmable base address ranges, numbered 1 and 2. Then six decode windows are searched. A window only counts when it is tied to the range that matched in the first stage. The window that wins gives the DRAM chip-select attribute, the local target code and the translated local address.

An access that matches a range but no window goes either to a programmable fallback route or is reported as unsupported. All settings live in a flat 32-bit register file with single-cycle writes and combinational reads. Results appear one clock after the request, on a registered output stage.

Top module: `inb_pcie_decode`

## Requirements
- R1: After reset every register reads 0, and any inbound access gives out_hit=0, out_unsup=0 and out_dflt=0.
- R2: The registers read back what was last written, at these byte offsets:
  - range n (n=1,2): control at 0x1804+(n-1)*4, low address at 0x10+n*8, high address at 0x14+n*8;
  - windows 0..4: control, base and remap at 0x1820+n*16, +4 and +0xC;
  - window 5: control, base and remap at 0x1880, 0x1884 and 0x188C;
  - fallback control at 0x18B0;
  - ROM holding registers at 0x18C0 and 0x18C4.
  
  Any other offset reads 0.
- R3: A range matches when all three hold: its control bit 0 is 1, its high address register is 0, and addr[31:16] equals low[31:16] outside the mask held in control[31:16] (size-1, in 64 KB units). When both ranges match, range 1 wins.
- R4: A window matches when all three hold: its control bit 0 is 1, its control bits [3:1] equal the number of the matched range, and addr[31:16] equals base[31:16] outside the mask in control[31:16]. A window tied to the other range, or disabled, is ignored.
- R5: When several windows match, the lowest-numbered window is used.
- R6: On a window hit, the local address is (remap & ~mask) | (addr & mask), where mask = {control[31:16], 16'hFFFF}. A remap of 0 leaves the address unchanged.
- R7: A range hit with no window hit, while fallback control bit 0 is 1, gives out_hit=1 and out_dflt=1. Target comes from fallback control [7:4], attribute from [15:8], and the address is unchanged.
- R8: A range hit with no window hit, while fallback control bit 0 is 0, gives out_unsup=1 and out_hit=0. out_hit and out_unsup are never both 1.
- R9: An address that matches no range gives out_hit=0 and out_unsup=0, even if some window's range covers it.
- R10: out_valid is in_valid delayed by one clock, and all result fields are registered on that same edge.
- R11: On a window hit, out_target is window control [7:4] and out_attr is control [15:8]. DRAM chip-select attributes are one-hot-low: 0xE, 0xD, 0xB, 0x7. When out_hit is 0, target, attribute and address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| in_valid | input | 1 | Inbound access present |
| in_addr | input | 32 | Inbound access address |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_hit | output | 1 | Access routed (window or fallback) |
| out_dflt | output | 1 | Access routed by the fallback control |
| out_unsup | output | 1 | Range matched but nothing routes it |
| out_target | output | 4 | Local target code |
| out_attr | output | 8 | Target attribute |
| out_addr | output | 32 | Translated local address |

## Verification
The assertions assume that register writes and inbound accesses are clean, known values on every clock after reset. They also assume that a register write in the same cycle as an access may be seen by either the old or the new setting. The bench keeps these two apart: every register write finishes before the next access is driven. Inputs change only on the falling edge and are held steady until it. Window ranges are always programmed inside their range, so each expected route is unambiguous.

// File: rtl/inb_dec_pkg.sv
package inb_dec_pkg;
   localparam int unsigned DW       = 32;
   localparam int unsigned GRAN_LSB = 16;

   typedef struct packed {
      logic [DW-1:0] ctrl;
      logic [DW-1:0] lo;
      logic [DW-1:0] hi;
   } bar_regs_t;

   typedef struct packed {
      logic [DW-1:0] ctrl;
      logic [DW-1:0] base;
      logic [DW-1:0] remap;
   } win_regs_t;

   localparam logic [15:0] OFF_DFLT      = 16'h18B0;
   localparam logic [15:0] OFF_ROM_CTRL  = 16'h18C0;
   localparam logic [15:0] OFF_ROM_REMAP = 16'h18C4;

   // i is the zero-based range slot, range number is i+1
   function automatic logic [15:0] bar_ctrl_off(int unsigned i);
      return 16'(16'h1804 + i * 4);
   endfunction
   function automatic logic [15:0] bar_lo_off(int unsigned i);
      return 16'(16'h0010 + (i + 1) * 8);
   endfunction
   function automatic logic [15:0] bar_hi_off(int unsigned i);
      return 16'(16'h0014 + (i + 1) * 8);
   endfunction

   // slot 5 sits apart from the regular stride
   function automatic logic [15:0] win_ctrl_off(int unsigned n);
      return (n < 5) ? 16'(16'h1820 + n * 16) : 16'h1880;
   endfunction
   function automatic logic [15:0] win_base_off(int unsigned n);
      return 16'(win_ctrl_off(n) + 16'h4);
   endfunction
   function automatic logic [15:0] win_remap_off(int unsigned n);
      return 16'(win_ctrl_off(n) + 16'hC);
   endfunction

   function automatic logic [DW-1:0] size_mask(logic [DW-1:0] ctrl);
      return {ctrl[31:16], 16'hFFFF};
   endfunction

   function automatic logic in_range(logic [DW-1:0] addr, logic [DW-1:0] base,
                                     logic [DW-1:0] ctrl);
      return (((addr ^ base) & ~size_mask(ctrl)) == '0);
   endfunction
endpackage

// File: rtl/inb_dec_regs.sv
module inb_dec_regs
   import inb_dec_pkg::*;
#(
   parameter int unsigned NUM_BAR = 2,
   parameter int unsigned NUM_WIN = 6,
   parameter int unsigned REG_AW  = 13
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_we,
   input  logic [REG_AW-1:0]                 reg_addr,
   input  logic [DW-1:0]                     reg_wdata,
   output logic [DW-1:0]                     reg_rdata,
   output bar_regs_t [NUM_BAR-1:0]           bars_o,
   output win_regs_t [NUM_WIN-1:0]           wins_o,
   output logic [DW-1:0]                     dflt_o
);
   bar_regs_t [NUM_BAR-1:0] bar_q;
   win_regs_t [NUM_WIN-1:0] win_q;
   logic [DW-1:0] dflt_q, rom_ctrl_q, rom_remap_q;

   function automatic logic hit(logic [REG_AW-1:0] a, logic [15:0] off);
      return a == REG_AW'(off);
   endfunction

   for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bar_q[i] <= '0;
         end else if (reg_we) begin
            if (hit(reg_addr, bar_ctrl_off(i))) bar_q[i].ctrl <= reg_wdata;
            if (hit(reg_addr, bar_lo_off(i)))   bar_q[i].lo   <= reg_wdata;
            if (hit(reg_addr, bar_hi_off(i)))   bar_q[i].hi   <= reg_wdata;
         end
      end
   end

   for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_q[n] <= '0;
         end else if (reg_we) begin
            if (hit(reg_addr, win_ctrl_off(n)))  win_q[n].ctrl  <= reg_wdata;
            if (hit(reg_addr, win_base_off(n)))  win_q[n].base  <= reg_wdata;
            if (hit(reg_addr, win_remap_off(n))) win_q[n].remap <= reg_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dflt_q      <= '0;
         rom_ctrl_q  <= '0;
         rom_remap_q <= '0;
      end else if (reg_we) begin
         if (hit(reg_addr, OFF_DFLT))      dflt_q      <= reg_wdata;
         if (hit(reg_addr, OFF_ROM_CTRL))  rom_ctrl_q  <= reg_wdata;
         if (hit(reg_addr, OFF_ROM_REMAP)) rom_remap_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_BAR; i++) begin
         if (hit(reg_addr, bar_ctrl_off(i))) reg_rdata = bar_q[i].ctrl;
         if (hit(reg_addr, bar_lo_off(i)))   reg_rdata = bar_q[i].lo;
         if (hit(reg_addr, bar_hi_off(i)))   reg_rdata = bar_q[i].hi;
      end
      for (int n = 0; n < NUM_WIN; n++) begin
         if (hit(reg_addr, win_ctrl_off(n)))  reg_rdata = win_q[n].ctrl;
         if (hit(reg_addr, win_base_off(n)))  reg_rdata = win_q[n].base;
         if (hit(reg_addr, win_remap_off(n))) reg_rdata = win_q[n].remap;
      end
      if (hit(reg_addr, OFF_DFLT))      reg_rdata = dflt_q;
      if (hit(reg_addr, OFF_ROM_CTRL))  reg_rdata = rom_ctrl_q;
      if (hit(reg_addr, OFF_ROM_REMAP)) reg_rdata = rom_remap_q;
   end

   assign bars_o = bar_q;
   assign wins_o = win_q;
   assign dflt_o = dflt_q;

   // R2: a write to range 1 control lands in the register on the next edge
   assert_bar_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && hit(reg_addr, bar_ctrl_off(0))) |=> (bar_q[0].ctrl == $past(reg_wdata)));
endmodule

// File: rtl/inb_dec_bar_match.sv
module inb_dec_bar_match
   import inb_dec_pkg::*;
#(
   parameter int unsigned NUM_BAR = 2
) (
   input  bar_regs_t [NUM_BAR-1:0] bars_i,
   input  logic [DW-1:0]           addr_i,
   output logic                    bar_hit_o,
   output logic [2:0]              bar_num_o
);
   logic [NUM_BAR-1:0] match;

   for (genvar i = 0; i < NUM_BAR; i++) begin : g_cmp
      assign match[i] = bars_i[i].ctrl[0] && (bars_i[i].hi == '0) &&
                        in_range(addr_i, bars_i[i].lo, bars_i[i].ctrl);
   end

   // lower-numbered range takes precedence
   always_comb begin
      bar_hit_o = 1'b0;
      bar_num_o = '0;
      for (int i = NUM_BAR - 1; i >= 0; i--) begin
         if (match[i]) begin
            bar_hit_o = 1'b1;
            bar_num_o = 3'(i + 1);
         end
      end
   end
endmodule

// File: rtl/inb_dec_win_match.sv
module inb_dec_win_match
   import inb_dec_pkg::*;
#(
   parameter int unsigned NUM_WIN = 6
) (
   input  win_regs_t [NUM_WIN-1:0] wins_i,
   input  logic [DW-1:0]           addr_i,
   input  logic                    bar_hit_i,
   input  logic [2:0]              bar_num_i,
   output logic                    win_hit_o,
   output logic [3:0]              target_o,
   output logic [7:0]              attr_o,
   output logic [DW-1:0]           loc_addr_o
);
   logic [NUM_WIN-1:0]  match;
   logic [DW-1:0]       xlat [NUM_WIN];

   for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
      logic [DW-1:0] m;
      assign m        = size_mask(wins_i[n].ctrl);
      assign match[n] = bar_hit_i && wins_i[n].ctrl[0] &&
                        (wins_i[n].ctrl[3:1] == bar_num_i) &&
                        in_range(addr_i, wins_i[n].base, wins_i[n].ctrl);
      assign xlat[n]  = (wins_i[n].remap[31:16] == '0) ? addr_i :
                        ((wins_i[n].remap & ~m) | (addr_i & m));
   end

   // scan from the top so the lowest matching slot is the last to assign
   always_comb begin
      win_hit_o  = 1'b0;
      target_o   = '0;
      attr_o     = '0;
      loc_addr_o = '0;
      for (int n = NUM_WIN - 1; n >= 0; n--) begin
         if (match[n]) begin
            win_hit_o  = 1'b1;
            target_o   = wins_i[n].ctrl[7:4];
            attr_o     = wins_i[n].ctrl[15:8];
            loc_addr_o = xlat[n];
         end
      end
   end
endmodule

// File: rtl/inb_pcie_decode.sv
module inb_pcie_decode
   import inb_dec_pkg::*;
#(
   parameter int unsigned NUM_BAR = 2,
   parameter int unsigned NUM_WIN = 6,
   parameter int unsigned REG_AW  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              in_valid,
   input  logic [31:0]       in_addr,
   output logic              out_valid,
   output logic              out_hit,
   output logic              out_dflt,
   output logic              out_unsup,
   output logic [3:0]        out_target,
   output logic [7:0]        out_attr,
   output logic [31:0]       out_addr
);
   if (NUM_BAR < 1 || NUM_BAR > 2) begin : g_bad_bar
      $error("NUM_BAR must be 1 or 2");
   end
   if (NUM_WIN < 1 || NUM_WIN > 6) begin : g_bad_win
      $error("NUM_WIN must be in 1..6");
   end
   if (REG_AW < 13) begin : g_bad_aw
      $error("REG_AW must cover offset 0x18C4");
   end

   bar_regs_t [NUM_BAR-1:0] bars;
   win_regs_t [NUM_WIN-1:0] wins;
   logic [DW-1:0] dflt_ctrl;
   logic          bar_hit, win_hit;
   logic [2:0]    bar_num;
   logic [3:0]    w_target;
   logic [7:0]    w_attr;
   logic [DW-1:0] w_addr;

   inb_dec_regs #(.NUM_BAR(NUM_BAR), .NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .bars_o(bars), .wins_o(wins), .dflt_o(dflt_ctrl));

   inb_dec_bar_match #(.NUM_BAR(NUM_BAR)) u_bar (
      .bars_i(bars), .addr_i(in_addr), .bar_hit_o(bar_hit), .bar_num_o(bar_num));

   inb_dec_win_match #(.NUM_WIN(NUM_WIN)) u_win (
      .wins_i(wins), .addr_i(in_addr), .bar_hit_i(bar_hit), .bar_num_i(bar_num),
      .win_hit_o(win_hit), .target_o(w_target), .attr_o(w_attr), .loc_addr_o(w_addr));

   logic          use_dflt, nx_hit, nx_unsup;
   logic [3:0]    nx_target;
   logic [7:0]    nx_attr;
   logic [DW-1:0] nx_addr;

   always_comb begin
      use_dflt  = bar_hit && !win_hit && dflt_ctrl[0];
      nx_hit    = win_hit || use_dflt;
      nx_unsup  = bar_hit && !win_hit && !dflt_ctrl[0];
      nx_target = '0;
      nx_attr   = '0;
      nx_addr   = '0;
      if (win_hit) begin
         nx_target = w_target;
         nx_attr   = w_attr;
         nx_addr   = w_addr;
      end else if (use_dflt) begin
         nx_target = dflt_ctrl[7:4];
         nx_attr   = dflt_ctrl[15:8];
         nx_addr   = in_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_hit    <= 1'b0;
         out_dflt   <= 1'b0;
         out_unsup  <= 1'b0;
         out_target <= '0;
         out_attr   <= '0;
         out_addr   <= '0;
      end else begin
         out_valid  <= in_valid;
         out_hit    <= in_valid && nx_hit;
         out_dflt   <= in_valid && use_dflt;
         out_unsup  <= in_valid && nx_unsup;
         out_target <= in_valid ? nx_target : '0;
         out_attr   <= in_valid ? nx_attr   : '0;
         out_addr   <= in_valid ? nx_addr   : '0;
      end
   end

   assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hit_unsup_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_hit && out_unsup));
   assert_dflt_implies_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_dflt |-> (out_hit && out_valid));
   assert_win_needs_bar_R9: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> bar_hit);
endmodule

// File: tb/sim_inb_pcie_decode.sv
module sim_inb_pcie_decode;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [12:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic in_valid = 1'b0;
   logic [31:0] in_addr = '0;
   logic out_valid, out_hit, out_dflt, out_unsup;
   logic [3:0] out_target;
   logic [7:0] out_attr;
   logic [31:0] out_addr;
   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   inb_pcie_decode u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
      .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
      .out_dflt(out_dflt), .out_unsup(out_unsup), .out_target(out_target),
      .out_attr(out_attr), .out_addr(out_addr));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a[12:0]; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [15:0] a, logic [31:0] exp);
      @(negedge clk);
      reg_addr = a[12:0];
      #1 chk(tag, reg_rdata, exp);
   endtask

   task automatic acc(string tag, logic [31:0] a, logic hit, logic dflt, logic unsup,
                      logic [3:0] tgt, logic [7:0] attr, logic [31:0] la);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a;
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " valid"}, 32'(out_valid), 32'd1);
      chk({tag, " flags"}, {29'd0, out_hit, out_dflt, out_unsup}, {29'd0, hit, dflt, unsup});
      chk({tag, " route"}, {20'd0, out_target, out_attr}, {20'd0, tgt, attr});
      chk({tag, " addr"}, out_addr, la);
   endtask

   task automatic t_reset_R1();
      rd_chk("R1 bar1 ctrl", 16'h1804, 0);
      rd_chk("R1 win5 ctrl", 16'h1880, 0);
      acc("R1 access", 32'h8000_0000, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_regs_R2();
      wr(16'h0018, 32'h8000_0000); wr(16'h1804, 32'h000F_0001);
      wr(16'h0020, 32'h9000_0000); wr(16'h1808, 32'h0000_0001);
      wr(16'h1880, 32'h0000_0725); wr(16'h1884, 32'h9000_0000);
      wr(16'h188C, 32'h2000_0000);
      wr(16'h18C0, 32'hA5A5_0001); wr(16'h18C4, 32'h1234_0000);
      rd_chk("R2 bar1 lo", 16'h0018, 32'h8000_0000);
      rd_chk("R2 bar2 ctrl", 16'h1808, 32'h0000_0001);
      rd_chk("R2 win5 base", 16'h1884, 32'h9000_0000);
      rd_chk("R2 win5 remap", 16'h188C, 32'h2000_0000);
      rd_chk("R2 rom ctrl", 16'h18C0, 32'hA5A5_0001);
      rd_chk("R2 rom remap", 16'h18C4, 32'h1234_0000);
      rd_chk("R2 unmapped", 16'h1870, 0);
   endtask

   task automatic t_windows_R4_R5_R6_R11();
      wr(16'h1824, 32'h8000_0000); wr(16'h1820, 32'h0003_0E03);
      wr(16'h1834, 32'h8004_0000); wr(16'h183C, 32'h1000_0000);
      wr(16'h1830, 32'h0003_0D03);
      wr(16'h1844, 32'h8000_0000); wr(16'h184C, 32'h3000_0000);
      wr(16'h1840, 32'h0000_0B03);
      wr(16'h1854, 32'h9000_0000); wr(16'h1850, 32'h0000_5503);
      wr(16'h1864, 32'h8008_0000); wr(16'h1860, 32'h0000_5502);
      acc("R5 overlap win0", 32'h8000_1000, 1, 0, 0, 4'h0, 8'h0E, 32'h8000_1000);
      acc("R6 identity R11 cs0", 32'h8002_0040, 1, 0, 0, 4'h0, 8'h0E, 32'h8002_0040);
      acc("R6 remap R11 cs1", 32'h8004_1234, 1, 0, 0, 4'h0, 8'h0D, 32'h1000_1234);
      acc("R4 bar field win5", 32'h9000_0ABC, 1, 0, 0, 4'h2, 8'h07, 32'h2000_0ABC);
   endtask

   task automatic t_fallback_R7_R8();
      acc("R8 unsupported", 32'h8008_0010, 0, 0, 1, 0, 0, 0);
      wr(16'h18B0, 32'h0000_3A31);
      acc("R7 fallback", 32'h8008_0010, 1, 1, 0, 4'h3, 8'h3A, 32'h8008_0010);
      acc("R3 bar1 top edge", 32'h800F_FFFC, 1, 1, 0, 4'h3, 8'h3A, 32'h800F_FFFC);
      wr(16'h18B0, 32'h0);
   endtask

   task automatic t_nobar_R3_R9();
      acc("R3 past bar1", 32'h8010_0000, 0, 0, 0, 0, 0, 0);
      wr(16'h1834, 32'h7000_0000); wr(16'h1830, 32'h0003_0D03);
      acc("R9 window without bar", 32'h7000_0010, 0, 0, 0, 0, 0, 0);
      wr(16'h0024, 32'h0000_0001);
      acc("R3 bar2 high nonzero", 32'h9000_0ABC, 0, 0, 0, 0, 0, 0);
      wr(16'h0024, 32'h0);
   endtask

   task automatic t_timing_R10();
      @(negedge clk);
      chk("R10 idle", 32'(out_valid), 0);
      acc("R10 one-cycle", 32'h9000_0004, 1, 0, 0, 4'h2, 8'h07, 32'h2000_0004);
      @(negedge clk);
      chk("R10 drop", 32'(out_valid), 0);
   endtask

   initial begin
      fork
         begin : wd
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
         end
         begin
            repeat (3) @(posedge clk);
            @(negedge clk) rst_n = 1'b1;
            t_reset_R1();
            t_regs_R2();
            t_windows_R4_R5_R6_R11();
            t_fallback_R7_R8();
            t_nobar_R3_R9();
            t_timing_R10();
         end
      join_any
      disable fork;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule